// File: doc/BRIEF.md
# CAN Receive Ring-Buffer Controller

This block places received CAN frames into a circular buffer of 16-byte message slots held in memory. Each incoming frame goes through an identifier acceptance filter. A frame that passes is given the slot at the current write position. The block then raises a store request that carries the slot's byte offset from the buffer base and the normalised identifier. It holds that request until a store-done handshake confirms the memory transfer. The write position then advances by one slot and wraps at the configured buffer size.

Software consumes slots and hands them back by moving the read position. The block always keeps one slot empty, so a frame is refused whenever storing it would make the write position catch up with the read position. A one-cycle interrupt fires when a completed store brings the write position onto a programmed threshold.

A frame is dropped when the filter rejects it, when the ring is full, or when a store is still outstanding. Each drop increments a saturating counter. All settings are reached through a small word-addressed register port.

Top module: `can_rx_ring`

## Requirements
- R1: After reset the register port reads: filter mask (word 3) = 0x1FFFFFFF, filter code (word 4) = 0, read position (word 0), write position (word 1) and threshold (word 2) = 0, size (word 5) = SLOT_W, drop counter (word 6) = 0. After reset store_req_o and irq_o are low.
- R2: Words 0, 1 and 2 hold a slot index in bits 4 upward, so their value is a byte offset in 16-byte slots. Bits 3:0 always read zero, whatever was written to them.
- R3: A frame is accepted only when, for every bit set in the 29-bit mask, the normalised identifier bit equals the same bit of the code. Bits clear in the mask are ignored.
- R4: A standard frame (frame_ext_i=0) takes its 11-bit identifier from frame_id_i[10:0] and places it at bits 28:18, with bits 17:0 zero. An extended frame uses frame_id_i[28:0] as is.
- R5: An accepted and stored frame raises store_req_o in the cycle after frame_valid_i is sampled. store_addr_o is the write position's byte offset and store_id_o is the normalised identifier. Both are held unchanged until store_done_i is sampled.
- R6: On store_done_i the write position advances one slot and wraps to 0 after slot 2^size-1. It changes at no other time.
- R7: A frame is not stored when advancing the write position would make it equal the read position (taken modulo the ring size). One slot always stays free.
- R8: irq_o pulses high for exactly one cycle, right after the store-done edge, when the new write position equals the threshold register.
- R9: Every dropped frame (filter reject, ring full, or store busy) increments an 8-bit drop counter (word 6). The counter stays at 255 once there, and a drop leaves the write position unchanged.
- R10: Only one store is outstanding at a time. A frame that arrives while store_req_o is high is dropped.
- R11: Word 5 takes log2 of the slot count in bits 7:0. A written 0 becomes 1, and a value above SLOT_W becomes SLOT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| frame_valid_i | input | 1 | Frame strobe, one cycle per frame |
| frame_ext_i | input | 1 | 1 = extended identifier |
| frame_id_i | input | 29 | Received identifier |
| store_req_o | output | 1 | Store request, held until done |
| store_addr_o | output | 32 | Slot byte offset from buffer base |
| store_id_o | output | 29 | Normalised identifier of stored frame |
| store_done_i | input | 1 | Memory transfer completed |
| irq_o | output | 1 | Threshold interrupt pulse |

## Verification
The bench shrinks the ring to four slots and fills it. It checks that the frame which would close the gap is refused; a design that used all slots would overwrite unread data there. It then releases slots and drives the write position across the wrap, where a wrong size mask would send stores past the buffer.

Standard and extended frames are sent against a standard-only mask. This exposes a filter that compares unmasked bits or places the 11-bit identifier at the wrong position. Further cases cover a frame arriving during an outstanding store, the threshold pulse landing on exactly one store, and the drop counter being driven past 255, where a wrapping counter would read back a small value.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int ID_W     = 29;
  localparam int STD_W    = 11;
  localparam int SLOT_B   = 4;   // log2 of slot bytes
  localparam int DROP_W   = 8;

  typedef enum logic [2:0] {
    RA_READ  = 3'd0,
    RA_WRITE = 3'd1,
    RA_IRQ   = 3'd2,
    RA_MASK  = 3'd3,
    RA_CODE  = 3'd4,
    RA_SIZE  = 3'd5,
    RA_DROP  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/can_rx_filter.sv
module can_rx_filter
  import can_rx_pkg::*;
(
  input  logic            ext_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic [ID_W-1:0] code_i,
  output logic [ID_W-1:0] id_norm_o,
  output logic            hit_o
);
  localparam int EXT_LO = ID_W - STD_W;

  always_comb begin
    if (ext_i) id_norm_o = id_i;
    else       id_norm_o = {id_i[STD_W-1:0], {EXT_LO{1'b0}}};
  end

  assign hit_o = ((id_norm_o ^ code_i) & mask_i) == '0;
endmodule

// File: rtl/can_rx_regs.sv
module can_rx_regs
  import can_rx_pkg::*;
#(
  parameter int SLOT_W = 12,
  parameter int LOG_W  = $clog2(SLOT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [SLOT_W-1:0] wr_ptr_i,
  input  logic [DROP_W-1:0] drop_cnt_i,
  output logic [SLOT_W-1:0] rd_ptr_o,
  output logic [SLOT_W-1:0] irq_ptr_o,
  output logic [ID_W-1:0]   mask_o,
  output logic [ID_W-1:0]   code_o,
  output logic [LOG_W-1:0]  size_log2_o
);
  logic [7:0]       sz_raw;
  logic [LOG_W-1:0] sz_clamped;
  logic             unused_wdata;

  assign sz_raw       = wdata_i[7:0];
  assign unused_wdata = ^wdata_i[31:ID_W];

  always_comb begin
    if (sz_raw == 8'd0)                    sz_clamped = LOG_W'(1);
    else if (32'(sz_raw) > 32'(SLOT_W))    sz_clamped = LOG_W'(SLOT_W);
    else                                   sz_clamped = sz_raw[LOG_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_o    <= '0;
      irq_ptr_o   <= '0;
      mask_o      <= '1;
      code_o      <= '0;
      size_log2_o <= LOG_W'(SLOT_W);
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        RA_READ: rd_ptr_o    <= wdata_i[SLOT_B +: SLOT_W];
        RA_IRQ:  irq_ptr_o   <= wdata_i[SLOT_B +: SLOT_W];
        RA_MASK: mask_o      <= wdata_i[ID_W-1:0];
        RA_CODE: code_o      <= wdata_i[ID_W-1:0];
        RA_SIZE: size_log2_o <= sz_clamped;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr_e'(addr_i))
      RA_READ:  rdata_o = 32'(rd_ptr_o)  << SLOT_B;
      RA_WRITE: rdata_o = 32'(wr_ptr_i)  << SLOT_B;
      RA_IRQ:   rdata_o = 32'(irq_ptr_o) << SLOT_B;
      RA_MASK:  rdata_o = 32'(mask_o);
      RA_CODE:  rdata_o = 32'(code_o);
      RA_SIZE:  rdata_o = 32'(size_log2_o);
      RA_DROP:  rdata_o = 32'(drop_cnt_i);
      default:  rdata_o = '0;
    endcase
  end

  p_size_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_log2_o >= LOG_W'(1)) && (32'(size_log2_o) <= 32'(SLOT_W)));

  p_ptr_nibble_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == RA_READ || addr_i == RA_WRITE || addr_i == RA_IRQ) |-> rdata_o[SLOT_B-1:0] == '0);
endmodule

// File: rtl/can_rx_ring_ctrl.sv
module can_rx_ring_ctrl
  import can_rx_pkg::*;
#(
  parameter int SLOT_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic              frame_hit_i,
  input  logic [ID_W-1:0]   frame_id_i,
  input  logic [SLOT_W-1:0] slot_mask_i,
  input  logic [SLOT_W-1:0] rd_ptr_i,
  input  logic [SLOT_W-1:0] irq_ptr_i,
  input  logic              store_done_i,
  output logic              busy_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [ID_W-1:0]   id_o,
  output logic [SLOT_W-1:0] wr_ptr_o,
  output logic              irq_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic [SLOT_W-1:0] wr_m, wr_next, rd_m, irq_m;
  logic              full, take, drop, finish;

  assign wr_m    = wr_ptr_o & slot_mask_i;
  assign wr_next = (wr_m + SLOT_W'(1)) & slot_mask_i;
  assign rd_m    = rd_ptr_i & slot_mask_i;
  assign irq_m   = irq_ptr_i & slot_mask_i;
  assign full    = (wr_next == rd_m);
  assign take    = frame_valid_i && frame_hit_i && !full && !busy_o;
  assign drop    = frame_valid_i && !take;
  assign finish  = busy_o && store_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      slot_o   <= '0;
      id_o     <= '0;
      wr_ptr_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (finish) begin
        busy_o   <= 1'b0;
        wr_ptr_o <= wr_next;
        irq_o    <= (wr_next == irq_m);
      end else if (take) begin
        busy_o <= 1'b1;
        slot_o <= wr_m;
        id_o   <= frame_id_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       drop_cnt_o <= '0;
    else if (drop && drop_cnt_o != '1) drop_cnt_o <= drop_cnt_o + DROP_W'(1);
  end

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !store_done_i) |=> busy_o && $stable(slot_o) && $stable(id_o));

  p_wr_only_on_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && store_done_i) |=> $stable(wr_ptr_o));

  p_irq_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_after_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(busy_o && store_done_i));

  p_never_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (((slot_o + SLOT_W'(1)) & slot_mask_i) != (rd_ptr_i & slot_mask_i)));

  p_drop_saturate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o == '1) |=> (drop_cnt_o == '1));

  p_single_store_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !store_done_i && frame_valid_i) |=> busy_o && $stable(slot_o));
endmodule

// File: rtl/can_rx_ring.sv
module can_rx_ring
  import can_rx_pkg::*;
#(
  parameter int SLOT_W = 12,
  localparam int LOG_W = $clog2(SLOT_W + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        frame_valid_i,
  input  logic        frame_ext_i,
  input  logic [28:0] frame_id_i,
  output logic        store_req_o,
  output logic [31:0] store_addr_o,
  output logic [28:0] store_id_o,
  input  logic        store_done_i,
  output logic        irq_o
);
  logic [SLOT_W-1:0] rd_ptr, irq_ptr, wr_ptr, slot, slot_mask;
  logic [ID_W-1:0]   mask, code, id_norm;
  logic [LOG_W-1:0]  size_log2;
  logic [DROP_W-1:0] drop_cnt;
  logic              hit;

  for (genvar g = 0; g < SLOT_W; g++) begin : g_mask
    assign slot_mask[g] = (32'(size_log2) > g);
  end

  can_rx_regs #(.SLOT_W(SLOT_W), .LOG_W(LOG_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .wr_ptr_i    (wr_ptr),
    .drop_cnt_i  (drop_cnt),
    .rd_ptr_o    (rd_ptr),
    .irq_ptr_o   (irq_ptr),
    .mask_o      (mask),
    .code_o      (code),
    .size_log2_o (size_log2)
  );

  can_rx_filter i_filter (
    .ext_i     (frame_ext_i),
    .id_i      (frame_id_i),
    .mask_i    (mask),
    .code_i    (code),
    .id_norm_o (id_norm),
    .hit_o     (hit)
  );

  can_rx_ring_ctrl #(.SLOT_W(SLOT_W)) i_ctrl (
    .clk_i, .rst_ni,
    .frame_valid_i,
    .frame_hit_i  (hit),
    .frame_id_i   (id_norm),
    .slot_mask_i  (slot_mask),
    .rd_ptr_i     (rd_ptr),
    .irq_ptr_i    (irq_ptr),
    .store_done_i,
    .busy_o       (store_req_o),
    .slot_o       (slot),
    .id_o         (store_id_o),
    .wr_ptr_o     (wr_ptr),
    .irq_o,
    .drop_cnt_o   (drop_cnt)
  );

  assign store_addr_o = 32'(slot) << SLOT_B;

  p_addr_in_ring_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |-> (slot & ~slot_mask) == '0);
endmodule

// File: tb/test_can_rx_ring.sv
module test_can_rx_ring;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W = 12;

  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fv = 0, fext = 0, done = 0;
  logic [28:0] fid = 0;
  logic        store_req, irq;
  logic [31:0] store_addr;
  logic [28:0] store_id;

  int checks = 0, errors = 0;
  logic [31:0] exp_addr_q[$];
  logic [28:0] exp_id_q[$];
  bit          seen = 0;

  // bench model
  int m_wr = 0, m_rd = 0, m_irq = 0, m_log = SLOT_W, m_drop = 0;
  logic [28:0] m_mask = 29'h1FFFFFFF, m_code = 0;
  bit m_busy = 0;

  can_rx_ring #(.SLOT_W(SLOT_W)) i_can_rx_ring (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .frame_valid_i(fv), .frame_ext_i(fext), .frame_id_i(fid),
    .store_req_o(store_req), .store_addr_o(store_addr), .store_id_o(store_id),
    .store_done_i(done), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare each new store request with the scoreboard
  always @(negedge clk) begin
    if (store_req && !seen) begin
      seen = 1;
      if (exp_addr_q.size() == 0) chk(0, "R5 unexpected store", store_addr, 32'hFFFFFFFF);
      else begin
        logic [31:0] ea;
        logic [28:0] ei;
        ea = exp_addr_q.pop_front();
        ei = exp_id_q.pop_front();
        chk(store_addr == ea, "R5 store addr", store_addr, ea);
        chk(store_id == ei, "R4 store id", 32'(store_id), 32'(ei));
      end
    end
    if (!store_req) seen = 0;
  end

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string req);
    logic [31:0] d;
    rd_reg(a, d);
    chk(d === e, req, d, e);
  endtask

  function automatic logic [28:0] norm(input logic ext, input logic [28:0] id);
    return ext ? id : {id[10:0], 18'd0};
  endfunction

  task automatic finish_store();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    m_wr = (m_wr + 1) % (1 << m_log);
    m_busy = 0;
    chk(irq === (m_wr == m_irq), "R8 irq pulse", 32'(irq), 32'(m_wr == m_irq));
    chk(store_req === 1'b0, "R5 req drops after done", 32'(store_req), 0);
    expect_reg(3'd1, 32'(m_wr) << 4, "R6 write position");
    @(negedge clk);
    chk(irq === 1'b0, "R8 irq one cycle", 32'(irq), 0);
  endtask

  task automatic send(input logic ext, input logic [28:0] id, input bit complete);
    logic [28:0] n;
    bit hit, full, take;
    n = norm(ext, id);
    hit = ((n ^ m_code) & m_mask) == 0;
    full = ((m_wr + 1) % (1 << m_log)) == (m_rd % (1 << m_log));
    take = hit && !full && !m_busy;
    if (take) begin
      exp_addr_q.push_back(32'(m_wr) << 4);
      exp_id_q.push_back(n);
    end
    @(negedge clk); fv = 1; fext = ext; fid = id;
    @(negedge clk); fv = 0;
    if (take) m_busy = 1;
    else if (m_drop < 255) m_drop++;
    chk(store_req === m_busy, "R3/R7/R10 store decision", 32'(store_req), 32'(m_busy));
    expect_reg(3'd6, 32'(m_drop), "R9 drop count");
    if (complete && m_busy) finish_store();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_reg(3'd0, 0, "R1 read reset");
    expect_reg(3'd1, 0, "R1 write reset");
    expect_reg(3'd2, 0, "R1 irq reset");
    expect_reg(3'd3, 32'h1FFFFFFF, "R1 mask reset");
    expect_reg(3'd4, 0, "R1 code reset");
    expect_reg(3'd5, SLOT_W, "R1 size reset");
    expect_reg(3'd6, 0, "R1 drop reset");
    chk(store_req === 0 && irq === 0, "R1 outputs reset", {store_req, irq}, 0);

    // R11 size clamp
    wr_reg(3'd5, 0);  expect_reg(3'd5, 1, "R11 clamp low");
    wr_reg(3'd5, 40); expect_reg(3'd5, SLOT_W, "R11 clamp high");
    wr_reg(3'd5, 2);  expect_reg(3'd5, 2, "R11 size 4 slots");
    m_log = 2;

    // R2 pointer format
    wr_reg(3'd0, 32'h35); expect_reg(3'd0, 32'h30, "R2 low nibble zero");
    wr_reg(3'd0, 0);
    wr_reg(3'd2, 32'h2F); expect_reg(3'd2, 32'h20, "R2 irq nibble zero");
    m_irq = 2;

    // R3/R4 filter on standard id bits only
    m_mask = 29'h1FFC0000; m_code = {11'h123, 18'd0};
    wr_reg(3'd3, 32'(m_mask));
    wr_reg(3'd4, 32'(m_code));
    send(0, 29'h123, 1);                    // R4 std accepted, slot 0
    send(1, {11'h123, 18'h00055}, 1);       // R3 ext bits unmasked, slot 1 -> irq
    send(1, {11'h124, 18'h00000}, 1);       // R3 reject
    send(0, 29'h122, 1);                    // R3 reject
    send(0, 29'h1FFFF123, 1);               // R4 upper input bits ignored for std, slot 2
    // R7 ring full: wr=3, rd=0
    send(0, 29'h123, 1);
    chk(m_wr == 3, "R7 model wr", 32'(m_wr), 3);
    expect_reg(3'd1, 32'h30, "R7 write unchanged on full");
    // release and wrap (R6)
    wr_reg(3'd0, 32'h20); m_rd = 2;
    send(0, 29'h123, 1);                    // slot 3 -> wrap to 0
    expect_reg(3'd1, 0, "R6 wrap to zero");
    // R10 busy drop
    send(0, 29'h123, 0);                    // slot 0 outstanding
    send(1, {11'h123, 18'h1}, 0);           // dropped while busy
    chk(store_req === 1, "R10 store still pending", 32'(store_req), 1);
    finish_store();                         // wr 1
    send(0, 29'h123, 1);                    // full again (wr1->2==rd2)
    // R9 saturation
    m_code = 0; wr_reg(3'd4, 0);
    for (int i = 0; i < 260; i++) begin
      @(negedge clk); fv = 1; fext = 0; fid = 29'h7FF;
    end
    @(negedge clk); fv = 0;
    m_drop = 255;
    expect_reg(3'd6, 255, "R9 saturate");
    expect_reg(3'd1, 32'(m_wr) << 4, "R9 write unchanged on drop");
    chk(exp_addr_q.size() == 0, "R5 scoreboard empty", exp_addr_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule